// File: doc/BRIEF.md
# Quad-SPI Transfer FIFO and Status Flags

This block sits between the register bus of a quad-SPI controller and its phase sequencer. It holds a byte FIFO that carries payload in either direction, the control and status registers for that path, and the logic that raises the interrupt and the DMA request. Software or a DMA engine moves payload through a byte-wide data register. The sequencer moves the same bytes through its own push and pop ports, and it reports when an operation starts, finishes, fails or has been aborted.

A direction bit in the control register decides which side fills the FIFO. In receive direction the sequencer pushes and the bus pops. In transmit direction the bus pushes and the sequencer pops. A programmable threshold drives one flag that means "enough data to read" in receive direction and "enough room to write" in transmit direction. That flag feeds the DMA request line and, when enabled, the interrupt.

Top module: `qfs_xfer_status`

## Requirements
- R1: The register index selects control (0), status (1), flag-clear (2) and data (3). Status holds the error flag at bit 0, the complete flag at bit 1, the threshold flag at bit 2, busy at bit 5 and the FIFO level at bits 13:8. Control reads back the direction bit 0 (1 = receive), DMA enable bit 2, threshold bits 12:8 and the interrupt enables at bits 16 (error), 17 (complete) and 18 (threshold). Every other control bit, and every flag-clear read, returns 0.
- R2: A sequencer error pulse sets the error flag and a done pulse sets the complete flag. Writing 1 to flag-clear bit 0 clears the error flag and writing 1 to bit 1 clears the complete flag. When a set and a clear arrive in the same cycle, the set wins.
- R3: The FIFO holds 32 bytes. A push into a full FIFO and a pop from an empty one are each dropped and leave the level unchanged.
- R4: Bytes leave the FIFO in the order they entered. A data-register write pushes write-data bits 7:0. A data-register read returns the oldest byte in bits 7:0 and pops it. The sequencer pop port shows the oldest byte whenever the FIFO is not empty.
- R5: In receive direction only sequencer pushes and bus data reads act on the FIFO. In transmit direction only bus data writes and sequencer pops act on it. Requests from the other side are ignored, and a bus data read in transmit direction returns 0.
- R6: With threshold value N, the threshold flag is high when the level is at least N+1 in receive direction, and when 32 minus the level is at least N+1 in transmit direction.
- R7: The interrupt output is high exactly when some flag is set whose enable bit is set.
- R8: The DMA request is high exactly when DMA enable is set and the threshold flag is high.
- R9: Busy rises in the cycle after a start pulse and stays high until a done, error or abort-complete pulse. A start pulse wins over an end pulse in the same cycle.
- R10: An abort-complete pulse empties the FIFO, so the level reads 0 from the next cycle on. Any push or pop requested in that same cycle is dropped.
- R11: After reset the level is 0, all flags and control bits are 0, and the interrupt and DMA request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data register) |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid in the cycle of the read |
| seq_start | input | 1 | Operation start pulse |
| seq_done | input | 1 | Operation finished pulse |
| seq_err | input | 1 | Operation error pulse |
| seq_abort_done | input | 1 | Abort completed pulse |
| seq_push | input | 1 | Sequencer pushes a received byte |
| seq_push_data | input | 8 | Received byte |
| seq_pop | input | 1 | Sequencer takes a byte to send |
| seq_pop_data | output | 8 | Oldest FIFO byte |
| fifo_full | output | 1 | FIFO holds 32 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions check the following on every cycle:
- the level never goes above the depth, and a push into a full FIFO leaves it full;
- an accepted lone push raises the level by one, and an abort-complete pulse leaves the level at zero;
- error and start pulses set their flags, and a complete-clear without a done pulse clears the complete flag;
- busy holds while no end pulse arrives, and the interrupt stays quiet while no flag is set.

Only the bench scenarios can show the following:
- that bytes come out in order and with the right values;
- that the threshold flips at the exact level for each direction and threshold value;
- that requests from the wrong side of the FIFO are ignored;
- that the register read-back and the interrupt and DMA enable gating are correct.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_FCLR = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  localparam int CTRL_DIR_BIT   = 0;
  localparam int CTRL_DMA_BIT   = 2;
  localparam int CTRL_THR_LSB   = 8;
  localparam int CTRL_IE_TE_BIT = 16;
  localparam int CTRL_IE_TC_BIT = 17;
  localparam int CTRL_IE_FT_BIT = 18;

  localparam int ST_TE_BIT   = 0;
  localparam int ST_TC_BIT   = 1;
  localparam int ST_FT_BIT   = 2;
  localparam int ST_BUSY_BIT = 5;
  localparam int ST_LVL_LSB  = 8;

  // Threshold rule: count what the bus side can use (bytes to read in
  // receive direction, free slots in transmit direction) against thr+1.
  function automatic logic thresh_met(input logic [31:0] level,
                                      input logic [31:0] depth,
                                      input logic [31:0] thr,
                                      input logic        rx);
    logic [31:0] avail;
    avail = rx ? level : (depth - level);
    return avail >= (thr + 32'd1);
  endfunction

  // Wrap-around increment for a FIFO pointer of any depth.
  function automatic logic [31:0] ptr_next(input logic [31:0] p,
                                           input logic [31:0] depth);
    return (p == depth - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/qfs_ctrl_reg.sv
module qfs_ctrl_reg import qfs_pkg::*; #(
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic             dir_rx,
  output logic             dma_en,
  output logic [THR_W-1:0] thr,
  output logic             ie_te,
  output logic             ie_tc,
  output logic             ie_ft,
  output logic [31:0]      readback
);
  localparam logic [31:0] THR_MASK  = ((32'd1 << THR_W) - 32'd1) << CTRL_THR_LSB;
  localparam logic [31:0] CTRL_MASK = (32'd1 << CTRL_DIR_BIT) | (32'd1 << CTRL_DMA_BIT) |
                                      THR_MASK | (32'd1 << CTRL_IE_TE_BIT) |
                                      (32'd1 << CTRL_IE_TC_BIT) | (32'd1 << CTRL_IE_FT_BIT);

  logic [31:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata & CTRL_MASK;
  end

  assign dir_rx   = ctrl_q[CTRL_DIR_BIT];
  assign dma_en   = ctrl_q[CTRL_DMA_BIT];
  assign thr      = ctrl_q[CTRL_THR_LSB +: THR_W];
  assign ie_te    = ctrl_q[CTRL_IE_TE_BIT];
  assign ie_tc    = ctrl_q[CTRL_IE_TC_BIT];
  assign ie_ft    = ctrl_q[CTRL_IE_FT_BIT];
  assign readback = ctrl_q;
endmodule

// File: rtl/qfs_fifo.sv
module qfs_fifo import qfs_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_ev,
  output logic          pop_ev
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ev = push_req && !full && !flush;
  assign pop_ev  = pop_req && !empty && !flush;
  assign head    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (push_ev) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ev) wp <= AW'(ptr_next(32'(wp), DEPTH));
      if (pop_ev)  rp <= AW'(ptr_next(32'(rp), DEPTH));
      case ({push_ev, pop_ev})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/qfs_flags.sv
module qfs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_start,
  input  logic seq_done,
  input  logic seq_err,
  input  logic abort_done,
  input  logic clr_te,
  input  logic clr_tc,
  output logic te,
  output logic tc,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te   <= 1'b0;
      tc   <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (seq_err)     te <= 1'b1;
      else if (clr_te) te <= 1'b0;
      if (seq_done)    tc <= 1'b1;
      else if (clr_tc) tc <= 1'b0;
      if (seq_start)   busy <= 1'b1;
      else if (seq_done || seq_err || abort_done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/qfs_xfer_status.sv
module qfs_xfer_status import qfs_pkg::*; #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        seq_start,
  input  logic        seq_done,
  input  logic        seq_err,
  input  logic        seq_abort_done,
  input  logic        seq_push,
  input  logic [7:0]  seq_push_data,
  input  logic        seq_pop,
  output logic [7:0]  seq_pop_data,
  output logic        fifo_full,
  output logic        fifo_empty,
  output logic        irq,
  output logic        dma_req
);
  // Named events, shared with the bound checker.
  logic          ctrl_wr, fclr_wr, data_wr, data_rd;
  logic          fclr_te, fclr_tc;
  logic          dir_rx, dma_en, ie_te, ie_tc, ie_ft;
  logic [AW-1:0] thr;
  logic [31:0]   ctrl_rb;
  logic          push_req, pop_req, push_ev, pop_ev, flush;
  logic [7:0]    push_data, head;
  logic [LW-1:0] level;
  logic          te, tc, busy, ft;
  logic [31:0]   stat_word;

  assign ctrl_wr = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
  assign fclr_wr = bus_wr && (reg_sel_e'(bus_addr) == REG_FCLR);
  assign data_wr = bus_wr && (reg_sel_e'(bus_addr) == REG_DATA);
  assign data_rd = bus_rd && (reg_sel_e'(bus_addr) == REG_DATA);
  assign fclr_te = fclr_wr && bus_wdata[ST_TE_BIT];
  assign fclr_tc = fclr_wr && bus_wdata[ST_TC_BIT];

  qfs_ctrl_reg #(.THR_W(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wdata    (bus_wdata),
    .dir_rx   (dir_rx),
    .dma_en   (dma_en),
    .thr      (thr),
    .ie_te    (ie_te),
    .ie_tc    (ie_tc),
    .ie_ft    (ie_ft),
    .readback (ctrl_rb)
  );

  // Direction steering: each side owns one end of the FIFO.
  assign flush     = seq_abort_done;
  assign push_req  = dir_rx ? seq_push      : data_wr;
  assign push_data = dir_rx ? seq_push_data : bus_wdata[7:0];
  assign pop_req   = dir_rx ? data_rd       : seq_pop;

  qfs_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_req  (push_req),
    .push_data (push_data),
    .pop_req   (pop_req),
    .head      (head),
    .level     (level),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .push_ev   (push_ev),
    .pop_ev    (pop_ev)
  );

  qfs_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_start  (seq_start),
    .seq_done   (seq_done),
    .seq_err    (seq_err),
    .abort_done (seq_abort_done),
    .clr_te     (fclr_te),
    .clr_tc     (fclr_tc),
    .te         (te),
    .tc         (tc),
    .busy       (busy)
  );

  assign ft = thresh_met(32'(level), DEPTH, 32'(thr), dir_rx);

  always_comb begin
    stat_word = '0;
    stat_word[ST_TE_BIT]   = te;
    stat_word[ST_TC_BIT]   = tc;
    stat_word[ST_FT_BIT]   = ft;
    stat_word[ST_BUSY_BIT] = busy;
    stat_word[ST_LVL_LSB +: LW] = level;
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_CTRL: bus_rdata = ctrl_rb;
      REG_STAT: bus_rdata = stat_word;
      REG_DATA: bus_rdata = (dir_rx && !fifo_empty) ? {24'd0, head} : 32'd0;
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign seq_pop_data = head;
  assign irq          = (te && ie_te) || (tc && ie_tc) || (ft && ie_ft);
  assign dma_req      = dma_en && ft;
endmodule

// File: rtl/qfs_xfer_status_chk.sv
module qfs_xfer_status_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] level,
  input logic          push_req,
  input logic          push_ev,
  input logic          pop_ev,
  input logic          flush,
  input logic          seq_start,
  input logic          seq_done,
  input logic          seq_err,
  input logic          seq_abort_done,
  input logic          fclr_tc,
  input logic          te,
  input logic          tc,
  input logic          busy,
  input logic          ft,
  input logic          irq
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(DEPTH) && push_req && !pop_ev && !flush) |=> level == LW'(DEPTH));

  a_r4_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_ev && !pop_ev) |=> level == LW'($past(level) + 1'b1));

  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort_done |=> level == '0);

  a_r2_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> te);

  a_r2_tc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fclr_tc && !seq_done) |=> !tc);

  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> busy);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done && !seq_err && !seq_abort_done) |=> busy);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !tc && !ft) |-> !irq);
endmodule

bind qfs_xfer_status qfs_xfer_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .level          (level),
  .push_req       (push_req),
  .push_ev        (push_ev),
  .pop_ev         (pop_ev),
  .flush          (flush),
  .seq_start      (seq_start),
  .seq_done       (seq_done),
  .seq_err        (seq_err),
  .seq_abort_done (seq_abort_done),
  .fclr_tc        (fclr_tc),
  .te             (te),
  .tc             (tc),
  .busy           (busy),
  .ft             (ft),
  .irq            (irq)
);

// File: tb/qfs_xfer_status_tb.sv
`timescale 1ns/1ps
module qfs_xfer_status_tb;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        seq_start, seq_done, seq_err, seq_abort_done;
  logic        seq_push, seq_pop;
  logic [7:0]  seq_push_data, seq_pop_data;
  logic        fifo_full, fifo_empty, irq, dma_req;

  always #2 clk = ~clk;

  qfs_xfer_status #(.DEPTH(DEPTH)) u_dut (.*);

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done_run = 0;
  string phase    = "R11";

  logic [7:0]  mq[$];
  logic        m_te = 0, m_tc = 0, m_busy = 0;
  logic [31:0] m_ctrl = 0;

  function automatic logic exp_ft(int lvl, logic [31:0] c);
    int thr   = int'((c >> 8) & 32'h1f);
    int avail = c[0] ? lvl : DEPTH - lvl;
    return avail > thr;
  endfunction

  function automatic logic [31:0] exp_stat();
    int lvl = mq.size();
    return {18'd0, 6'(lvl), 2'b00, m_busy, 2'b00, exp_ft(lvl, m_ctrl), m_tc, m_te};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (phase %s): actual %h expected %h", req, phase, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    seq_start = 0; seq_done = 0; seq_err = 0; seq_abort_done = 0;
    seq_push = 0; seq_pop = 0; seq_push_data = 0;
  endtask

  // One cycle: inputs already set at the falling edge.
  task automatic step(string rreq);
    int   lvl;
    logic ft, rx;
    #1;
    lvl = mq.size();
    rx  = m_ctrl[0];
    ft  = exp_ft(lvl, m_ctrl);
    check("R7", 32'(irq), 32'((m_te & m_ctrl[16]) | (m_tc & m_ctrl[17]) | (ft & m_ctrl[18])));
    check("R8", 32'(dma_req), 32'(m_ctrl[2] & ft));
    check("R3", 32'({fifo_full, fifo_empty}), 32'({lvl == DEPTH, lvl == 0}));
    if (!rx && lvl > 0) check("R4", 32'(seq_pop_data), 32'(mq[0]));
    if (bus_rd) begin
      case (bus_addr)
        2'd0:    check(rreq, bus_rdata, m_ctrl);
        2'd1:    check(rreq, bus_rdata, exp_stat());
        2'd2:    check(rreq, bus_rdata, 32'd0);
        default: check(rreq, bus_rdata, (rx && lvl > 0) ? 32'(mq[0]) : 32'd0);
      endcase
    end
    @(posedge clk);
    if (seq_abort_done) mq.delete();
    else begin
      logic       preq = rx ? seq_push : (bus_wr && bus_addr == 2'd3);
      logic [7:0] pd   = rx ? seq_push_data : bus_wdata[7:0];
      logic       qreq = rx ? (bus_rd && bus_addr == 2'd3) : seq_pop;
      logic       dpush = preq && (lvl < DEPTH);
      logic       dpop  = qreq && (lvl > 0);
      if (dpop)  void'(mq.pop_front());
      if (dpush) mq.push_back(pd);
    end
    if (seq_err) m_te = 1;
    else if (bus_wr && bus_addr == 2'd2 && bus_wdata[0]) m_te = 0;
    if (seq_done) m_tc = 1;
    else if (bus_wr && bus_addr == 2'd2 && bus_wdata[1]) m_tc = 0;
    if (seq_start) m_busy = 1;
    else if (seq_done || seq_err || seq_abort_done) m_busy = 0;
    if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata & 32'h0007_1F05;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step("R1");
  endtask

  task automatic rd_reg(logic [1:0] a, string req);
    bus_rd = 1; bus_addr = a; step(req);
  endtask

  initial begin
    #(4 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state.
    phase = "R11";
    rd_reg(2'd1, "R11");
    rd_reg(2'd0, "R11");
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, "R1");
    wr_reg(2'd0, 32'd0);
    rd_reg(2'd2, "R1");

    // R5 / R4: transmit direction, bus pushes, sequencer pops.
    phase = "R5";
    for (int i = 0; i < 5; i++) wr_reg(2'd3, 32'hA0 + i);
    seq_push = 1; seq_push_data = 8'h55; step("R5");
    rd_reg(2'd3, "R5");
    rd_reg(2'd1, "R5");
    phase = "R4";
    for (int i = 0; i < 5; i++) begin seq_pop = 1; step("R4"); end

    // R3: overfill and overdrain.
    phase = "R3";
    for (int i = 0; i < DEPTH + 2; i++) wr_reg(2'd3, 32'(i));
    rd_reg(2'd1, "R3");
    for (int i = 0; i < DEPTH + 2; i++) begin seq_pop = 1; step("R3"); end
    rd_reg(2'd1, "R3");

    // R6 / R8 / R7: receive direction, threshold 3, DMA and threshold irq.
    phase = "R6";
    wr_reg(2'd0, 32'h0004_0305);
    for (int i = 0; i < 6; i++) begin
      seq_push = 1; seq_push_data = 8'(8'h30 + i); step("R6");
      rd_reg(2'd1, "R6");
    end
    wr_reg(2'd3, 32'h77);
    rd_reg(2'd1, "R5");
    for (int i = 0; i < 7; i++) rd_reg(2'd3, "R4");
    wr_reg(2'd0, 32'h0000_1F00);
    rd_reg(2'd1, "R6");

    // R2: error/complete flags, clears and same-cycle priority.
    phase = "R2";
    wr_reg(2'd0, 32'h0003_0000);
    seq_err = 1; step("R2");
    rd_reg(2'd1, "R2");
    wr_reg(2'd2, 32'd1);
    rd_reg(2'd1, "R2");
    seq_done = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'd2; step("R2");
    rd_reg(2'd1, "R2");
    wr_reg(2'd2, 32'd3);
    rd_reg(2'd1, "R2");

    // R9: busy tracking.
    phase = "R9";
    seq_start = 1; step("R9");
    repeat (3) rd_reg(2'd1, "R9");
    seq_done = 1; step("R9");
    rd_reg(2'd1, "R9");
    seq_start = 1; seq_err = 1; step("R9");
    rd_reg(2'd1, "R9");
    seq_abort_done = 1; step("R9");
    rd_reg(2'd1, "R9");
    wr_reg(2'd2, 32'd3);

    // R10: abort flushes, concurrent push dropped.
    phase = "R10";
    wr_reg(2'd0, 32'd0);
    for (int i = 0; i < 9; i++) wr_reg(2'd3, 32'(8'hC0 + i));
    seq_abort_done = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 32'hEE; step("R10");
    rd_reg(2'd1, "R10");
    wr_reg(2'd3, 32'h12);
    seq_pop = 1; step("R10");

    // Random traffic.
    phase = "random";
    for (int c = 0; c < 4000; c++) begin
      int r = int'($urandom % 100);
      if (r < 3) begin
        bus_wr = 1; bus_addr = 2'd0;
        bus_wdata = $urandom & 32'h0007_1F05;
      end else if (r < 30) begin
        bus_wr = 1; bus_addr = 2'd3; bus_wdata = $urandom;
      end else if (r < 55) begin
        bus_rd = 1; bus_addr = 2'($urandom % 4);
      end else if (r < 60) begin
        bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'($urandom % 4);
      end
      seq_push      = ($urandom % 3) == 0;
      seq_push_data = 8'($urandom);
      seq_pop       = ($urandom % 3) == 0;
      seq_start     = ($urandom % 20) == 0;
      seq_done      = ($urandom % 25) == 0;
      seq_err       = ($urandom % 40) == 0;
      seq_abort_done = ($urandom % 60) == 0;
      step(bus_addr == 2'd1 ? "R6" : "R1");
    end

    finish_run();
  end
endmodule